// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the general register file of a 32-bit multi-mode processor. Software always sees fifteen general registers plus the program counter. Which physical storage stands behind each of those names depends on the processor mode presented on `mode_i`. Thirty physical general registers back the fifteen logical ones:

- Registers 0 to 7 are common to every mode.
- The fast-interrupt mode has its own copies of registers 8 to 12.
- Each mode bank owns its own stack-pointer and link registers, logical 13 and 14. User and System modes share one bank.

The block also keeps the program counter, a single current status word, and one saved status word for each privileged exception mode.

Two combinational read ports and one synchronous write port address registers by logical index. A link strobe stores a return address into the link register of the current mode's bank. The program counter and the two status words each have their own load strobe. The mode input selects the mapping combinationally. A mode change therefore affects reads at once, and every bank keeps its contents across the change.

Top module: `banked_regfile`

## Requirements
- R1: After the active-low asynchronous reset, every register reads zero: all general registers, the program counter, the current status word and every saved status word.
- R2: A write with `wr_en_i` high to logical index 0..14 stores `wr_data_i` into the register that index maps to in the current mode, and it is visible on the read ports after the next rising edge.
- R3: Logical registers 0 to 7 are one physical set, shared by every mode.
- R4: Logical registers 8 to 12 are one set shared by all modes except fast-interrupt (`mode_i` = 5'b10001), which has a private set of five.
- R5: Logical registers 13 and 14 have six banks: User (5'b10000) with System (5'b11111), fast-interrupt, IRQ (5'b10010), Supervisor (5'b10011), Abort (5'b10111) and Undefined (5'b11011).
- R6: Logical index 15 reads return the program counter in every mode. The program counter changes only through `pc_we_i`, and a write-port access to index 15 changes no register.
- R7: `link_en_i` stores `link_data_i` into logical 14 of the current bank on the next edge. If the write port targets logical 14 in the same cycle, the link value wins. A write-port access to any other index in that cycle still lands.
- R8: `cpsr_o` is one register, the same in every mode, loaded through `cpsr_we_i` on the next edge.
- R9: Each of the five privileged modes other than System has its own saved status word, loaded by `spsr_we_i` while in that mode and shown on `spsr_o`. In User or System mode, `spsr_o` shows the current status word and `spsr_we_i` changes nothing.
- R10: Reads follow `mode_i` combinationally, so a new mode's mapping applies at once, and no bank loses contents when the mode changes.
- R11: A `mode_i` value outside the seven listed encodings is treated as User mode for register mapping and saved status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 5 | Current processor mode encoding |
| rd_idx_i | input | NUM_RD x 4 | Logical index per read port |
| rd_data_o | output | NUM_RD x XLEN | Read data per port, combinational |
| wr_en_i | input | 1 | Write-port enable |
| wr_idx_i | input | 4 | Write-port logical index |
| wr_data_i | input | XLEN | Write-port data |
| link_en_i | input | 1 | Store return address into current-bank link register |
| link_data_i | input | XLEN | Return address |
| pc_we_i | input | 1 | Program counter load |
| pc_data_i | input | XLEN | Program counter load value |
| pc_o | output | XLEN | Program counter |
| cpsr_we_i | input | 1 | Current status load |
| cpsr_data_i | input | XLEN | Current status load value |
| cpsr_o | output | XLEN | Current status word |
| spsr_we_i | input | 1 | Saved status load for the current mode |
| spsr_data_i | input | XLEN | Saved status load value |
| spsr_o | output | XLEN | Saved status of the current mode |

## Verification
Reads carry no register stage, so a changed mode or index is checked a short settle delay later, inside the same clock period. Every load is due one rising edge after its strobe: the general, link, program counter and status writes alike. The bench drives each strobe on a falling edge, lets one rising edge pass, and checks on the following falling edge. Near-exhaustive sweeps write every logical index in all seven modes and in one unlisted encoding. After each sweep, every index is read back in every mode on both ports and compared with a bench model that copies each write to all modes sharing that register.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;
  localparam logic [4:0] MODE_SYS = 5'b11111;

  localparam int LREG_W     = 4;
  localparam int SHARED_LO  = 8;
  localparam int FIQ_SHADOW = 5;
  localparam int NUM_BANKS  = 6;
  localparam int LREG_SP    = SHARED_LO + FIQ_SHADOW;
  localparam int LREG_LR    = LREG_SP + 1;
  localparam int LREG_PC    = LREG_LR + 1;
  localparam int FIQ_BASE   = SHARED_LO + FIQ_SHADOW;
  localparam int BANK_BASE  = FIQ_BASE + FIQ_SHADOW;
  localparam int NUM_PHYS   = BANK_BASE + 2 * NUM_BANKS;
  localparam int PIDX_W     = $clog2(NUM_PHYS);
  localparam int NUM_SPSR   = NUM_BANKS - 1;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;
endpackage

// File: rtl/mode_decode.sv
module mode_decode
  import regbank_pkg::*;
(
  input  logic [4:0] mode_i,
  output bank_e      bank_o
);
  // System and unlisted encodings fold onto the User bank
  always_comb begin
    unique case (mode_i)
      MODE_FIQ: bank_o = BK_FIQ;
      MODE_IRQ: bank_o = BK_IRQ;
      MODE_SVC: bank_o = BK_SVC;
      MODE_ABT: bank_o = BK_ABT;
      MODE_UND: bank_o = BK_UND;
      default:  bank_o = BK_USR;
    endcase
  end
endmodule

// File: rtl/bank_map.sv
module bank_map
  import regbank_pkg::*;
(
  input  bank_e              bank_i,
  input  logic [LREG_W-1:0]  lreg_i,
  output logic [PIDX_W-1:0]  pidx_o
);
  always_comb begin
    pidx_o = '0;
    if (lreg_i < LREG_W'(SHARED_LO)) begin
      pidx_o = PIDX_W'(lreg_i);
    end else if (lreg_i < LREG_W'(LREG_SP)) begin
      pidx_o = (bank_i == BK_FIQ)
             ? PIDX_W'(FIQ_BASE + int'(lreg_i) - SHARED_LO)
             : PIDX_W'(lreg_i);
    end else if (lreg_i <= LREG_W'(LREG_LR)) begin
      pidx_o = PIDX_W'(BANK_BASE + 2 * int'(bank_i) + int'(lreg_i) - LREG_SP);
    end
  end

  always_comb begin
    if (!$isunknown({bank_i, lreg_i})) begin
      if (bank_i == BK_FIQ && lreg_i >= LREG_W'(SHARED_LO) && lreg_i <= LREG_W'(LREG_LR))
        a_r4_fiq_private: assert (int'(pidx_o) >= FIQ_BASE && int'(pidx_o) < NUM_PHYS);
      if (lreg_i == LREG_W'(LREG_SP) || lreg_i == LREG_W'(LREG_LR))
        a_r5_banked_range: assert (int'(pidx_o) >= BANK_BASE && int'(pidx_o) < NUM_PHYS);
      if (lreg_i < LREG_W'(SHARED_LO))
        a_r3_low_shared: assert (pidx_o == PIDX_W'(lreg_i));
    end
  end
endmodule

// File: rtl/gpr_array.sv
module gpr_array
  import regbank_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int NUM_RD = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [PIDX_W-1:0]              widx_i,
  input  logic [XLEN-1:0]                wdata_i,
  input  logic                           lwe_i,
  input  logic [PIDX_W-1:0]              lidx_i,
  input  logic [XLEN-1:0]                ldata_i,
  input  logic [NUM_RD-1:0][PIDX_W-1:0]  ridx_i,
  output logic [NUM_RD-1:0][XLEN-1:0]    rdata_o
);
  logic [XLEN-1:0] rf_q [NUM_PHYS];

  for (genvar g = 0; g < NUM_PHYS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                rf_q[g] <= '0;
      else if (lwe_i && lidx_i == PIDX_W'(g))     rf_q[g] <= ldata_i;
      else if (we_i && widx_i == PIDX_W'(g))      rf_q[g] <= wdata_i;
    end
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    assign rdata_o[r] = (int'(ridx_i[r]) < NUM_PHYS) ? rf_q[ridx_i[r]] : '0;
  end

  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !(lwe_i && lidx_i == widx_i)) |=> rf_q[$past(widx_i)] == $past(wdata_i));

  // R7: link value lands, including over a same-slot port write
  a_r7_link_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lwe_i |=> rf_q[$past(lidx_i)] == $past(ldata_i));
endmodule

// File: rtl/psr_store.sv
module psr_store
  import regbank_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  bank_e           bank_i,
  input  logic            cpsr_we_i,
  input  logic [XLEN-1:0] cpsr_data_i,
  input  logic            spsr_we_i,
  input  logic [XLEN-1:0] spsr_data_i,
  output logic [XLEN-1:0] cpsr_o,
  output logic [XLEN-1:0] spsr_o
);
  logic [XLEN-1:0] cpsr_q;
  logic [XLEN-1:0] spsr_q [NUM_SPSR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cpsr_q <= '0;
    else if (cpsr_we_i) cpsr_q <= cpsr_data_i;
  end

  for (genvar s = 0; s < NUM_SPSR; s++) begin : g_spsr
    localparam bank_e SlotBank = bank_e'(3'(s + 1));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                spsr_q[s] <= '0;
      else if (spsr_we_i && bank_i == SlotBank)   spsr_q[s] <= spsr_data_i;
    end

    a_r9_spsr_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (spsr_we_i && bank_i != SlotBank) |=> $stable(spsr_q[s]));
  end

  always_comb begin
    spsr_o = cpsr_q;
    for (int s = 0; s < NUM_SPSR; s++)
      if (bank_i == bank_e'(3'(s + 1))) spsr_o = spsr_q[s];
  end

  assign cpsr_o = cpsr_q;

  a_r8_cpsr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpsr_we_i |=> cpsr_o == $past(cpsr_data_i));

  a_r8_cpsr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpsr_we_i |=> $stable(cpsr_o));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import regbank_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int NUM_RD = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [4:0]                     mode_i,
  input  logic [NUM_RD-1:0][LREG_W-1:0]  rd_idx_i,
  output logic [NUM_RD-1:0][XLEN-1:0]    rd_data_o,
  input  logic                           wr_en_i,
  input  logic [LREG_W-1:0]              wr_idx_i,
  input  logic [XLEN-1:0]                wr_data_i,
  input  logic                           link_en_i,
  input  logic [XLEN-1:0]                link_data_i,
  input  logic                           pc_we_i,
  input  logic [XLEN-1:0]                pc_data_i,
  output logic [XLEN-1:0]                pc_o,
  input  logic                           cpsr_we_i,
  input  logic [XLEN-1:0]                cpsr_data_i,
  output logic [XLEN-1:0]                cpsr_o,
  input  logic                           spsr_we_i,
  input  logic [XLEN-1:0]                spsr_data_i,
  output logic [XLEN-1:0]                spsr_o
);
  bank_e                         bank;
  logic [NUM_RD-1:0][PIDX_W-1:0] rd_pidx;
  logic [NUM_RD-1:0][XLEN-1:0]   gpr_rd;
  logic [PIDX_W-1:0]             wr_pidx;
  logic [PIDX_W-1:0]             lr_pidx;
  logic                          wr_hit;
  logic [XLEN-1:0]               pc_q;

  mode_decode u_mode (.mode_i(mode_i), .bank_o(bank));

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rport
    bank_map u_rmap (.bank_i(bank), .lreg_i(rd_idx_i[r]), .pidx_o(rd_pidx[r]));
    assign rd_data_o[r] = (rd_idx_i[r] == LREG_W'(LREG_PC)) ? pc_q : gpr_rd[r];
  end

  bank_map u_wmap (.bank_i(bank), .lreg_i(wr_idx_i),         .pidx_o(wr_pidx));
  bank_map u_lmap (.bank_i(bank), .lreg_i(LREG_W'(LREG_LR)), .pidx_o(lr_pidx));

  // index 15 on the write port is not a general register
  assign wr_hit = wr_en_i && (wr_idx_i != LREG_W'(LREG_PC));

  gpr_array #(.XLEN(XLEN), .NUM_RD(NUM_RD)) u_gpr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_hit),
    .widx_i (wr_pidx),
    .wdata_i(wr_data_i),
    .lwe_i  (link_en_i),
    .lidx_i (lr_pidx),
    .ldata_i(link_data_i),
    .ridx_i (rd_pidx),
    .rdata_o(gpr_rd)
  );

  psr_store #(.XLEN(XLEN)) u_psr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bank_i     (bank),
    .cpsr_we_i  (cpsr_we_i),
    .cpsr_data_i(cpsr_data_i),
    .spsr_we_i  (spsr_we_i),
    .spsr_data_i(spsr_data_i),
    .cpsr_o     (cpsr_o),
    .spsr_o     (spsr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pc_q <= '0;
    else if (pc_we_i) pc_q <= pc_data_i;
  end

  assign pc_o = pc_q;

  a_r6_pc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_we_i |=> $stable(pc_o));

  a_r6_pc_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_i |=> pc_o == $past(pc_data_i));
endmodule

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [4:0]        mode_i = 5'b10000;
  logic [1:0][3:0]   rd_idx_i = '0;
  logic [1:0][31:0]  rd_data_o;
  logic              wr_en_i = 1'b0;
  logic [3:0]        wr_idx_i = '0;
  logic [31:0]       wr_data_i = '0;
  logic              link_en_i = 1'b0;
  logic [31:0]       link_data_i = '0;
  logic              pc_we_i = 1'b0;
  logic [31:0]       pc_data_i = '0;
  logic [31:0]       pc_o;
  logic              cpsr_we_i = 1'b0;
  logic [31:0]       cpsr_data_i = '0;
  logic [31:0]       cpsr_o;
  logic              spsr_we_i = 1'b0;
  logic [31:0]       spsr_data_i = '0;
  logic [31:0]       spsr_o;

  always #10 clk = ~clk;

  banked_regfile u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i),
    .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
    .link_en_i(link_en_i), .link_data_i(link_data_i),
    .pc_we_i(pc_we_i), .pc_data_i(pc_data_i), .pc_o(pc_o),
    .cpsr_we_i(cpsr_we_i), .cpsr_data_i(cpsr_data_i), .cpsr_o(cpsr_o),
    .spsr_we_i(spsr_we_i), .spsr_data_i(spsr_data_i), .spsr_o(spsr_o)
  );

  // mode index: 0 usr,1 fiq,2 irq,3 svc,4 abt,5 und,6 sys,7 unlisted
  logic [4:0]  mcode [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                             5'b10111, 5'b11011, 5'b11111, 5'b00000};
  logic [31:0] exp_r [8][15];
  logic [31:0] sp_m [6];
  logic [31:0] cpsr_m = '0;
  logic [31:0] pc_m = '0;
  int total = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;
  int seq = 0;

  function automatic int bk(int mi);
    case (mi)
      1: return 1; 2: return 2; 3: return 3; 4: return 4; 5: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic bit shares(int a, int b, int l);
    if (l < 8)  return 1'b1;
    if (l < 13) return (a == 1) == (b == 1);
    return bk(a) == bk(b);
  endfunction

  function automatic string tag_of(int l);
    if (l < 8)  return "R3";
    if (l < 13) return "R4";
    return "R5";
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] expv);
    total++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, expv);
    end
  endtask

  task automatic mput(int mi, int l, logic [31:0] v);
    for (int m = 0; m < 8; m++) if (shares(mi, m, l)) exp_r[m][l] = v;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(int mi, int l, logic [31:0] v);
    mode_i = mcode[mi]; wr_en_i = 1'b1; wr_idx_i = 4'(l); wr_data_i = v;
    tick();
    wr_en_i = 1'b0;
    if (l != 15) mput(mi, l, v);
    rd_idx_i[0] = 4'(l);
    #1;
    chk("R2", $sformatf("mode%0d reg%0d", mi, l), rd_data_o[0], (l == 15) ? pc_m : exp_r[mi][l]);
  endtask

  task automatic check_all(string ctx);
    for (int mi = 0; mi < 8; mi++) begin
      mode_i = mcode[mi];
      for (int l = 0; l < 15; l++) begin
        rd_idx_i[0] = 4'(l); rd_idx_i[1] = 4'(14 - l);
        #1;
        chk(tag_of(l), $sformatf("%s mode%0d p0 reg%0d", ctx, mi, l), rd_data_o[0], exp_r[mi][l]);
        chk(tag_of(14 - l), $sformatf("%s mode%0d p1 reg%0d", ctx, mi, 14 - l), rd_data_o[1], exp_r[mi][14 - l]);
      end
    end
  endtask

  task automatic check_psr(string ctx);
    for (int mi = 0; mi < 8; mi++) begin
      mode_i = mcode[mi];
      #1;
      chk("R8", $sformatf("%s cpsr mode%0d", ctx, mi), cpsr_o, cpsr_m);
      chk((mi == 7) ? "R11" : "R9", $sformatf("%s spsr mode%0d", ctx, mi), spsr_o,
          (bk(mi) == 0) ? cpsr_m : sp_m[bk(mi)]);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      total++; fails++;
      $display("FAIL watchdog act=%0d exp=<20000 cycles", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < 8; m++) for (int l = 0; l < 15; l++) exp_r[m][l] = '0;
    for (int b = 0; b < 6; b++) sp_m[b] = '0;
    repeat (3) @(negedge clk);
    // R1: state right after reset
    chk("R1", "pc", pc_o, 32'h0);
    chk("R1", "cpsr", cpsr_o, 32'h0);
    mode_i = mcode[3]; #1;
    chk("R1", "spsr svc", spsr_o, 32'h0);
    rst_ni = 1'b1;
    check_all("R1 reset");

    // sweep: every index in every mode
    for (int mi = 0; mi < 8; mi++)
      for (int l = 0; l < 15; l++) begin
        seq++;
        wr(mi, l, {8'hc0 | 8'(mi), 8'(l), 16'(seq)});
      end
    check_all("sweep");

    // R10: mode switch without a clock edge
    mode_i = mcode[2]; rd_idx_i[0] = 4'd14; #1;
    chk("R10", "irq lr", rd_data_o[0], exp_r[2][14]);
    mode_i = mcode[3]; #1;
    chk("R10", "svc lr after switch", rd_data_o[0], exp_r[3][14]);
    mode_i = mcode[1]; rd_idx_i[0] = 4'd9; #1;
    chk("R10", "fiq r9 after switch", rd_data_o[0], exp_r[1][9]);
    // R11: unlisted encoding reads the User bank
    mode_i = mcode[7]; rd_idx_i[0] = 4'd13; #1;
    chk("R11", "unlisted sp", rd_data_o[0], exp_r[0][13]);

    // R6: program counter
    pc_we_i = 1'b1; pc_data_i = 32'h0000_8abc; mode_i = mcode[4];
    tick();
    pc_we_i = 1'b0; pc_m = 32'h0000_8abc;
    chk("R6", "pc_o", pc_o, pc_m);
    for (int mi = 0; mi < 8; mi++) begin
      mode_i = mcode[mi]; rd_idx_i[0] = 4'd15; rd_idx_i[1] = 4'd15; #1;
      chk("R6", $sformatf("read15 p0 mode%0d", mi), rd_data_o[0], pc_m);
      chk("R6", $sformatf("read15 p1 mode%0d", mi), rd_data_o[1], pc_m);
    end
    wr(3, 15, 32'hdead_beef);
    chk("R6", "pc after port write 15", pc_o, pc_m);
    check_all("R6 after port write 15");

    // R7: link strobe per mode
    for (int mi = 0; mi < 8; mi++) begin
      mode_i = mcode[mi]; link_en_i = 1'b1; link_data_i = 32'h1100_0000 | 32'(mi);
      tick();
      link_en_i = 1'b0; mput(mi, 14, 32'h1100_0000 | 32'(mi));
      rd_idx_i[0] = 4'd14; #1;
      chk("R7", $sformatf("link mode%0d", mi), rd_data_o[0], exp_r[mi][14]);
    end
    // R7: collision on logical 14, link wins
    mode_i = mcode[1]; link_en_i = 1'b1; link_data_i = 32'h2222_0001;
    wr_en_i = 1'b1; wr_idx_i = 4'd14; wr_data_i = 32'h3333_0001;
    tick();
    link_en_i = 1'b0; wr_en_i = 1'b0; mput(1, 14, 32'h2222_0001);
    rd_idx_i[0] = 4'd14; #1;
    chk("R7", "collision fiq lr", rd_data_o[0], 32'h2222_0001);
    // R7: link plus port write elsewhere, both land
    mode_i = mcode[5]; link_en_i = 1'b1; link_data_i = 32'h2222_0002;
    wr_en_i = 1'b1; wr_idx_i = 4'd3; wr_data_i = 32'h3333_0002;
    tick();
    link_en_i = 1'b0; wr_en_i = 1'b0;
    mput(5, 14, 32'h2222_0002); mput(5, 3, 32'h3333_0002);
    rd_idx_i[0] = 4'd14; rd_idx_i[1] = 4'd3; #1;
    chk("R7", "dual und lr", rd_data_o[0], 32'h2222_0002);
    chk("R7", "dual und r3", rd_data_o[1], 32'h3333_0002);
    check_all("R7 after link");

    // R8 / R9: status words
    cpsr_we_i = 1'b1; cpsr_data_i = 32'h6000_00d3; mode_i = mcode[2];
    tick();
    cpsr_we_i = 1'b0; cpsr_m = 32'h6000_00d3;
    check_psr("R8 cpsr load");
    for (int mi = 1; mi < 6; mi++) begin
      mode_i = mcode[mi]; spsr_we_i = 1'b1; spsr_data_i = 32'h5000_0000 | 32'(mi * 17);
      tick();
      spsr_we_i = 1'b0; sp_m[mi] = 32'h5000_0000 | 32'(mi * 17);
    end
    check_psr("R9 spsr loads");
    for (int k = 0; k < 3; k++) begin
      int mi = (k == 0) ? 0 : (k == 1) ? 6 : 7;
      mode_i = mcode[mi]; spsr_we_i = 1'b1; spsr_data_i = 32'hbad0_0000 | 32'(k);
      tick();
      spsr_we_i = 1'b0;
      check_psr($sformatf("R9 ignored spsr write mode%0d", mi));
    end

    check_all("final");
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule